// File: doc/BRIEF.md
# Variable-Length Instruction Byte Framer

The framer takes instruction bytes one per cycle over a valid/ready handshake. It groups them into whole instructions of 1 to 6 bytes. The first byte of each instruction carries a length code. The framer decodes that code, collects the remaining bytes, and presents the finished instruction on a second valid/ready handshake. The instruction comes out left-aligned in a 48-bit word, together with its byte count and an error flag.

A static mode input selects how the length code is read. In field mode, the top three bits of the first byte give the length directly in binary. In prefix mode, a short bit prefix identifies the length. That prefix gives the common short instructions the shortest codes. The mode is read only when a first byte is accepted, and it then holds for the rest of that instruction.

The block sits between a byte fetch stream and an instruction decoder. Its job is framing only: it does no opcode or operand decoding and no buffering beyond one finished instruction.

Top module: `instr_framer`

## Requirements
- R1: In field mode (`len_mode` = 0), bits 7..5 of the first byte give the instruction length in bytes, and a value from 1 to 6 is reported unchanged on `pkt_len`.
- R2: In prefix mode (`len_mode` = 1), the length comes from the first byte as follows:
  - bit 7 equal to 0 gives 1 byte;
  - bits 7..6 equal to 10 give 2 bytes;
  - bits 7..6 equal to 11 give 3 plus the value of bits 5..4.
- R3: In field mode, a length field of 0 or 7 is illegal. The framer raises `pkt_err` with that byte, reports it as a 1-byte instruction, and treats the next byte as a new first byte. `pkt_err` is 0 for every legal instruction.
- R4: `pkt_word` holds the first byte in bits 47..40, and each later byte sits in the next lower byte lane. Byte lanes beyond the instruction length read as zero.
- R5: `pkt_valid` rises in the cycle after the clock edge that accepts the final byte of an instruction. For a 1-byte instruction, that is the cycle after its only byte is accepted.
- R6: With `pkt_ready` held high, the framer accepts one byte on every cycle, so back-to-back 2-byte instructions stream with no stall cycles.
- R7: While `pkt_valid` is high and `pkt_ready` is low, `byte_ready` is low and `pkt_word`, `pkt_len` and `pkt_err` stay stable. Under any backpressure pattern, every instruction is delivered exactly once and in order.
- R8: A synchronous active-low reset discards any partly collected instruction and clears `pkt_valid`. After reset, the next accepted byte is treated as a first byte.
- R9: `len_mode` is sampled only when a first byte is accepted. Changing it while the later bytes of an instruction are arriving does not change that instruction's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| len_mode | input | 1 | Length encoding select: 0 = field, 1 = prefix |
| byte_valid | input | 1 | Input byte is valid |
| byte_ready | output | 1 | Framer can accept a byte |
| byte_data | input | 8 | Instruction byte |
| pkt_valid | output | 1 | A finished instruction is presented |
| pkt_ready | input | 1 | Consumer takes the instruction |
| pkt_word | output | 48 | Instruction bytes, first byte in the top lane |
| pkt_len | output | 3 | Instruction length in bytes (1 to 6) |
| pkt_err | output | 1 | Illegal length code seen in the first byte |

## Verification
The bench uses the default 8-bit byte and 6-byte maximum. At that size, every one of the 256 first-byte values can be swept in both modes, so each length code, both illegal field codes and all four prefix extensions are reached. Each sweep runs with the output always ready and again under pseudo-random backpressure. That combination places stalls on every byte position of every length. Directed sequences then cover:
- 1-byte latency;
- the stall-free 2-byte stream;
- a reset in the middle of an instruction;
- a mode change in the middle of an instruction.

// File: rtl/framer_pkg.sv
`timescale 1ns/1ps
// Package: shared sizes and the length-encoding selector for the framer.
// Assumes 8-bit bytes and at most 6 bytes per instruction; the prefix
// code layout is fixed by the four top bits of the first byte.
package framer_pkg;
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned MAX_BYTES = 6;
    localparam int unsigned LEN_W     = 3;
    localparam int unsigned HEAD_W    = 4;

    typedef enum logic {
        ENC_FIELD  = 1'b0,
        ENC_PREFIX = 1'b1
    } enc_mode_e;
endpackage

// File: rtl/framer_len_decode.sv
`timescale 1ns/1ps
// Module: framer_len_decode
// Purpose: turns the top bits of a first byte into an instruction length
//          and an illegal-code flag, for either length encoding.
// Assumes: head is the top HEAD_W bits of the first byte (bit 3 = byte MSB);
//          purely combinational, the caller decides when the result counts.
module framer_len_decode
    import framer_pkg::*;
#(
    parameter int unsigned LW       = LEN_W,
    parameter int unsigned MAXB     = MAX_BYTES
) (
    input  enc_mode_e           mode,
    input  logic [HEAD_W-1:0]   head,
    output logic [LW-1:0]       len,
    output logic                bad
);
    localparam logic [LW-1:0] ONE   = LW'(1);
    localparam logic [LW-1:0] TWO   = LW'(2);
    localparam logic [LW-1:0] THREE = LW'(3);
    localparam logic [LW-1:0] LIMIT = LW'(MAXB);

    logic [LW-1:0] field_len;
    logic          field_bad;
    logic [LW-1:0] pre_len;

    // Field encoding: binary length in the top three bits.
    always_comb begin
        field_len = LW'(head[HEAD_W-1 -: 3]);
        field_bad = (field_len == '0) || (field_len > LIMIT);
    end

    // Prefix encoding: 0 -> 1 byte, 10 -> 2 bytes, 11xx -> 3 + xx bytes.
    always_comb begin
        if (!head[3])
            pre_len = ONE;
        else if (!head[2])
            pre_len = TWO;
        else
            pre_len = THREE + LW'(head[1:0]);
    end

    // Select by mode; an illegal field code is reported as one byte.
    always_comb begin
        if (mode == ENC_PREFIX) begin
            len = pre_len;
            bad = 1'b0;
        end else begin
            len = field_bad ? ONE : field_len;
            bad = field_bad;
        end
    end
endmodule

// File: rtl/framer_assembler.sv
`timescale 1ns/1ps
// Module: framer_assembler
// Purpose: collects the bytes of one instruction into a left-aligned word,
//          tracks the byte index against the decoded length and emits a
//          one-cycle finish strobe with the complete word.
// Assumes: the caller gates take with the downstream ready, so a finish
//          strobe is always absorbed by the output stage.
module framer_assembler
    import framer_pkg::*;
#(
    parameter int unsigned BW   = BYTE_W,
    parameter int unsigned MAXB = MAX_BYTES,
    parameter int unsigned LW   = LEN_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  enc_mode_e           mode,
    input  logic                take,
    input  logic [BW-1:0]       din,
    output logic                fin,
    output logic [BW*MAXB-1:0]  fin_word,
    output logic [LW-1:0]       fin_len,
    output logic                fin_err
);
    localparam int unsigned WW = BW * MAXB;
    localparam int unsigned CW = LW + 1;

    logic              busy;
    logic [LW-1:0]     cnt;
    logic [LW-1:0]     tgt_len;
    logic [WW-1:0]     acc;

    logic [LW-1:0]     dec_len;
    logic              dec_bad;
    logic              first;
    logic [LW-1:0]     idx;
    logic [LW-1:0]     cur_len;
    logic              last;
    logic [WW-1:0]     placed;

    framer_len_decode #(.LW(LW), .MAXB(MAXB)) u_dec (
        .mode (mode),
        .head (din[BW-1 -: HEAD_W]),
        .len  (dec_len),
        .bad  (dec_bad)
    );

    // Pick the position and length that apply to the byte on the input.
    always_comb begin
        first   = !busy;
        idx     = first ? '0 : cnt;
        cur_len = first ? dec_len : tgt_len;
        last    = ({1'b0, idx} + CW'(1)) == {1'b0, cur_len};
    end

    // One lane per byte position: the incoming byte lands in lane idx.
    for (genvar j = 0; j < MAXB; j++) begin : g_lane
        localparam int unsigned HI = WW - 1 - j * BW;
        always_comb begin
            if (idx == LW'(j))
                placed[HI -: BW] = din;
            else
                placed[HI -: BW] = acc[HI -: BW];
        end
    end

    // Finish strobe and the finished instruction for the output stage.
    always_comb begin
        fin      = take && last;
        fin_word = placed;
        fin_len  = cur_len;
        fin_err  = first && dec_bad;
    end

    // Collection state: index, latched length and partial word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            cnt     <= '0;
            tgt_len <= '0;
            acc     <= '0;
        end else if (take) begin
            if (last) begin
                busy <= 1'b0;
                cnt  <= '0;
                acc  <= '0;
            end else begin
                busy <= 1'b1;
                cnt  <= idx + LW'(1);
                acc  <= placed;
                if (first)
                    tgt_len <= dec_len;
            end
        end
    end

    // R9: the length latched for an instruction holds until it completes.
    assert_len_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(tgt_len));

    // R1: the collection index never reaches the latched length.
    assert_idx_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt < tgt_len) && (cnt != '0));

    // R8: reset leaves no partial instruction behind.
    assert_reset_clears_R8: assert property (@(posedge clk)
        !rst_n |=> !busy && (acc == '0));
endmodule

// File: rtl/framer_out_stage.sv
`timescale 1ns/1ps
// Module: framer_out_stage
// Purpose: holds one finished instruction on the output handshake and
//          produces the input-side ready, so nothing is dropped under stall.
// Assumes: a finish strobe only arrives while space_ok is high.
module framer_out_stage
    import framer_pkg::*;
#(
    parameter int unsigned WW = BYTE_W * MAX_BYTES,
    parameter int unsigned LW = LEN_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fin,
    input  logic [WW-1:0]   fin_word,
    input  logic [LW-1:0]   fin_len,
    input  logic            fin_err,
    output logic            space_ok,
    output logic            o_valid,
    input  logic            o_ready,
    output logic [WW-1:0]   o_word,
    output logic [LW-1:0]   o_len,
    output logic            o_err
);
    // Space exists when empty or when the held item leaves this cycle.
    always_comb space_ok = !o_valid || o_ready;

    // Output register: load a finished item, drop it once consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_valid <= 1'b0;
            o_word  <= '0;
            o_len   <= '0;
            o_err   <= 1'b0;
        end else if (fin) begin
            o_valid <= 1'b1;
            o_word  <= fin_word;
            o_len   <= fin_len;
            o_err   <= fin_err;
        end else if (o_ready) begin
            o_valid <= 1'b0;
        end
    end

    // R7: a stalled item keeps its contents.
    assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && !o_ready) |=> o_valid && $stable(o_word)
                                  && $stable(o_len) && $stable(o_err));

    // R7: no finish strobe can land on a stalled item.
    assert_no_overwrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && !o_ready) |-> !fin);

    // R3: an error item is always one byte long.
    assert_err_one_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && o_err) |-> (o_len == LW'(1)));

    // R4: a one-byte item has all lower lanes zero.
    assert_zero_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && o_len == LW'(1)) |-> (o_word[WW-9:0] == '0));
endmodule

// File: rtl/instr_framer.sv
`timescale 1ns/1ps
// Module: instr_framer (top)
// Purpose: frames a byte stream into 1..6 byte instructions by the length
//          code of each first byte, in field or prefix encoding.
// Assumes: len_mode changes only between instructions are meaningful; it is
//          read when a first byte is accepted.
module instr_framer
    import framer_pkg::*;
#(
    parameter int unsigned BW   = BYTE_W,
    parameter int unsigned MAXB = MAX_BYTES,
    parameter int unsigned LW   = LEN_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                len_mode,
    input  logic                byte_valid,
    output logic                byte_ready,
    input  logic [BW-1:0]       byte_data,
    output logic                pkt_valid,
    input  logic                pkt_ready,
    output logic [BW*MAXB-1:0]  pkt_word,
    output logic [LW-1:0]       pkt_len,
    output logic                pkt_err
);
    localparam int unsigned WW = BW * MAXB;

    logic          take;
    logic          fin;
    logic [WW-1:0] fin_word;
    logic [LW-1:0] fin_len;
    logic          fin_err;
    enc_mode_e     mode_e;

    // Map the raw mode pin to the encoding type and form the accept strobe.
    always_comb begin
        mode_e = enc_mode_e'(len_mode);
        take   = byte_valid && byte_ready;
    end

    framer_assembler #(.BW(BW), .MAXB(MAXB), .LW(LW)) u_asm (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode_e),
        .take     (take),
        .din      (byte_data),
        .fin      (fin),
        .fin_word (fin_word),
        .fin_len  (fin_len),
        .fin_err  (fin_err)
    );

    framer_out_stage #(.WW(WW), .LW(LW)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .fin      (fin),
        .fin_word (fin_word),
        .fin_len  (fin_len),
        .fin_err  (fin_err),
        .space_ok (byte_ready),
        .o_valid  (pkt_valid),
        .o_ready  (pkt_ready),
        .o_word   (pkt_word),
        .o_len    (pkt_len),
        .o_err    (pkt_err)
    );

    // R5: output valid follows an accepted final byte by one cycle.
    assert_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> pkt_valid);

    // R7: the input is stalled while an item waits.
    assert_in_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_ready) |-> !byte_ready);

    // R1: reported length is always within 1..MAXB.
    assert_len_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> (pkt_len >= LW'(1)) && (pkt_len <= LW'(MAXB)));
endmodule

// File: tb/sim_instr_framer.sv
`timescale 1ns/1ps
module sim_instr_framer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        len_mode = 1'b0;
    logic        byte_valid = 1'b0;
    logic        byte_ready;
    logic [7:0]  byte_data = '0;
    logic        pkt_valid;
    logic        pkt_ready = 1'b1;
    logic [47:0] pkt_word;
    logic [2:0]  pkt_len;
    logic        pkt_err;

    always #4 clk = ~clk;

    instr_framer u0 (
        .clk(clk), .rst_n(rst_n), .len_mode(len_mode),
        .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_data(byte_data),
        .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_word(pkt_word),
        .pkt_len(pkt_len), .pkt_err(pkt_err)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int stalls = 0;
    logic [47:0] exp_word [0:2047];
    logic [2:0]  exp_len  [0:2047];
    logic        exp_err  [0:2047];
    logic        exp_mode [0:2047];
    int wr = 0;
    int rd = 0;
    logic [15:0] lfsr = 16'hACE1;
    int bp_lvl = 0;   // 0: always ready, 1: ~75% ready, 2: ~25% ready

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic int calc_len(input bit m, input logic [7:0] b, output bit err);
        err = 1'b0;
        if (!m) begin
            if (b[7:5] == 3'd0 || b[7:5] == 3'd7) begin
                err = 1'b1;
                return 1;
            end
            return int'(b[7:5]);
        end
        if (!b[7]) return 1;
        if (!b[6]) return 2;
        return 3 + int'(b[5:4]);
    endfunction

    task automatic expect_pkt(input logic [47:0] w, input int len, input bit err, input bit m);
        exp_word[wr] = w;
        exp_len[wr]  = 3'(len);
        exp_err[wr]  = err;
        exp_mode[wr] = m;
        wr++;
    endtask

    // Drive one byte starting at a negedge; return at the negedge after it is taken.
    task automatic push(input bit m, input logic [7:0] b);
        bit ok;
        len_mode   = m;
        byte_valid = 1'b1;
        byte_data  = b;
        forever begin
            ok = byte_ready;
            if (!ok) stalls++;
            @(negedge clk);
            if (ok) break;
        end
        byte_valid = 1'b0;
    endtask

    // Build, record and send one instruction whose first byte is b.
    task automatic send_instr(input bit m, input logic [7:0] b);
        bit err;
        int len;
        logic [47:0] w;
        logic [7:0] nb;
        len = calc_len(m, b, err);
        w = '0;
        w[47:40] = b;
        for (int k = 1; k < len; k++) begin
            nb = 8'(int'(b) * 7 + k * 29 + int'(m) * 101 + 1);
            w[47 - 8*k -: 8] = nb;
        end
        expect_pkt(w, len, err, m);
        push(m, b);
        for (int k = 1; k < len; k++) push(m, w[47 - 8*k -: 8]);
    endtask

    // Output-side ready pattern, changed just after each rising edge.
    always @(posedge clk) begin
        cyc++;
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        #2;
        case (bp_lvl)
            0: pkt_ready = 1'b1;
            1: pkt_ready = lfsr[0] | lfsr[3];
            default: pkt_ready = lfsr[0] & lfsr[5];
        endcase
    end

    // Monitor: a handshake will occur at the next edge; compare the item.
    always @(negedge clk) begin
        if (rst_n && pkt_valid && pkt_ready) begin
            if (rd >= wr) begin
                check(1'b0, "R7 extra output", 64'(pkt_word), 64'(0));
            end else begin
                check(pkt_word == exp_word[rd], "R4 word", 64'(pkt_word), 64'(exp_word[rd]));
                if (exp_mode[rd])
                    check(pkt_len == exp_len[rd], "R2 len", 64'(pkt_len), 64'(exp_len[rd]));
                else
                    check(pkt_len == exp_len[rd], "R1 len", 64'(pkt_len), 64'(exp_len[rd]));
                check(pkt_err == exp_err[rd], "R3 err", 64'(pkt_err), 64'(exp_err[rd]));
                rd++;
            end
        end
    end

    task automatic drain();
        int guard = 0;
        while (rd < wr && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        check(rd == wr, "R7 all delivered", 64'(rd), 64'(wr));
    endtask

    // Watchdog.
    initial begin
        wait (cyc > 150000);
        check(1'b0, "watchdog", 64'(cyc), 64'(150000));
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(pkt_valid == 1'b0, "R8 reset valid", 64'(pkt_valid), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check(byte_ready == 1'b1, "R8 reset ready", 64'(byte_ready), 64'(1));

        // R5: one-byte latency, field code 1.
        expect_pkt(48'h20_00_00_00_00_00, 1, 1'b0, 1'b0);
        len_mode = 1'b0; byte_valid = 1'b1; byte_data = 8'h20;
        check(pkt_valid == 1'b0, "R5 before edge", 64'(pkt_valid), 64'(0));
        @(negedge clk);
        byte_valid = 1'b0;
        check(pkt_valid == 1'b1, "R5 one cycle later", 64'(pkt_valid), 64'(1));
        drain();

        // R6: back-to-back 2-byte prefix instructions, no stall.
        stalls = 0;
        for (int i = 0; i < 24; i++) send_instr(1'b1, 8'(8'h80 | i));
        check(stalls == 0, "R6 stall cycles", 64'(stalls), 64'(0));
        drain();

        // R1 R2 R3 R4: full sweep of first bytes in both modes, then under backpressure.
        for (int lvl = 0; lvl < 3; lvl++) begin
            bp_lvl = lvl;
            for (int m = 0; m < 2; m++)
                for (int b = 0; b < 256; b++) send_instr(1'(m), 8'(b));
            drain();
        end
        bp_lvl = 0;
        repeat (3) @(negedge clk);

        // R9: mode flips after the first byte; field length 3 must hold.
        expect_pkt(48'h60_FF_01_00_00_00, 3, 1'b0, 1'b0);
        push(1'b0, 8'h60);
        push(1'b1, 8'hFF);
        push(1'b1, 8'h01);
        drain();
        // R9: prefix 2-byte, then mode to field with an illegal-looking byte.
        expect_pkt(48'h80_E0_00_00_00_00, 2, 1'b0, 1'b1);
        push(1'b1, 8'h80);
        push(1'b0, 8'hE0);
        drain();

        // R8: reset in the middle of a 6-byte instruction.
        push(1'b0, 8'hC0);
        push(1'b0, 8'h11);
        push(1'b0, 8'h22);
        rst_n = 1'b0;
        @(negedge clk);
        check(pkt_valid == 1'b0, "R8 mid reset valid", 64'(pkt_valid), 64'(0));
        rst_n = 1'b1;
        expect_pkt(48'h3F_00_00_00_00_00, 1, 1'b0, 1'b1);
        push(1'b1, 8'h3F);
        drain();

        // R7: nothing further appears once idle.
        repeat (10) @(negedge clk);
        check(pkt_valid == 1'b0, "R7 idle after drain", 64'(pkt_valid), 64'(0));
        check(rd == wr, "R7 count match", 64'(rd), 64'(wr));

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule